// File: doc/BRIEF.md
# 72/64 Single-Error-Correct Double-Error-Detect Decoder

This block checks a 72-bit memory word read back from storage. The word holds 64 data bits and 8 check bits. When the caller pulses a strobe, the block forms an 8-bit syndrome from a fixed parity-check matrix. Every data column in that matrix has odd weight, and every check column is a unit vector. One clock later the block returns the data, corrected if needed, with one of three status codes:
- clean
- single-bit error corrected
- uncorrectable

For a corrected error it also gives the numeric index (0–71) of the flipped codeword bit, so software can log which bit failed.

A combinational encoder port on the same module produces the 8 check bits for a 64-bit data word. Write paths use it, and the testbench uses it to build clean codewords.

Top module: `secded72_decoder`

## Requirements
- R1: The matrix columns are fixed as follows.
  - Data positions 0–55 take the 56 byte values of weight three, in ascending order of their lowest set bit, then middle set bit, then highest set bit. Position 0 is 0x07, position 1 is 0x0B and position 55 is 0xE0.
  - Data positions 56–63 take 0x1F, 0x2F, 0x4F, 0x8F, 0x37, 0x57, 0x97, 0x67 in that order.
  - Check position 64+k takes the unit vector 1<<k.
  - Data bit i of the word is codeword position i. Check bit k is position 64+k.
- R2: `enc_check` is combinational. Bit j of it is the XOR of the data bits whose column has bit j set. A word stored with these check bits decodes with status 0 (clean), a zero syndrome and unchanged data.
- R3: `out_valid` is high in exactly the cycle after a cycle in which `in_valid` was sampled high. The result outputs change only on a strobe.
- R4: A single flipped data bit at position p (0–63) gives status 1 (corrected), `out_pos` = p, and `out_data` equal to the original data.
- R5: A single flipped check bit at position 64–71 gives status 1 and `out_pos` equal to that position, with `out_data` equal to the received data.
- R6: Two flipped bits anywhere in the codeword give status 2 (uncorrectable), `out_pos` = 0, and `out_data` equal to the received data.
- R7: A nonzero syndrome of odd weight that equals no column gives status 2, `out_pos` = 0, and the received data passes through unchanged.
- R8: `out_syndrome` is the XOR of the columns of all codeword positions that hold a one.
- R9: A synchronous active-high `rst` clears `out_valid`, `out_data`, `out_status`, `out_pos` and `out_syndrome` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Strobe: decode the word on `in_data`/`in_check` |
| in_data | input | 64 | Received data bits |
| in_check | input | 8 | Received check bits |
| enc_data | input | 64 | Data word to encode |
| enc_check | output | 8 | Check bits for `enc_data` |
| out_valid | output | 1 | Result valid, one cycle after the strobe |
| out_data | output | 64 | Corrected or passed-through data |
| out_status | output | 2 | 0 clean, 1 corrected, 2 uncorrectable |
| out_pos | output | 7 | Index of the corrected codeword bit, else 0 |
| out_syndrome | output | 8 | Computed syndrome |

## Verification
The assertions compare each registered result with the data sampled one cycle earlier. They therefore take for granted that `in_data` and `in_check` hold known values whenever `in_valid` is high, and that the strobe is sampled with its word in the same cycle.

The bench drives every input at the falling edge and holds the word across the next rising edge. It only ever applies fully defined codewords, built from random data, the encoder and chosen bit flips. These include all 72 single-bit positions, random double flips, and check-bit patterns that reach odd-weight syndromes outside the column set.

// File: rtl/secded72_decoder.sv
module secded72_decoder (
  input  logic        clk,
  input  logic        rst,
  input  logic        in_valid,
  input  logic [63:0] in_data,
  input  logic [7:0]  in_check,
  input  logic [63:0] enc_data,
  output logic [7:0]  enc_check,
  output logic        out_valid,
  output logic [63:0] out_data,
  output logic [1:0]  out_status,
  output logic [6:0]  out_pos,
  output logic [7:0]  out_syndrome
);
  localparam int DW = 64;
  localparam int CW = 8;
  localparam int NW = DW + CW;
  localparam logic [1:0] ST_CLEAN = 2'd0;
  localparam logic [1:0] ST_CORR  = 2'd1;
  localparam logic [1:0] ST_UNC   = 2'd2;

  function automatic logic [7:0] hcol(input int p);
    logic [7:0] r;
    int n;
    r = '0;
    n = 0;
    if (p >= DW) begin
      r = 8'd1 << (p - DW);
    end else if (p >= 56) begin
      case (p - 56)
        0: r = 8'h1F;
        1: r = 8'h2F;
        2: r = 8'h4F;
        3: r = 8'h8F;
        4: r = 8'h37;
        5: r = 8'h57;
        6: r = 8'h97;
        default: r = 8'h67;
      endcase
    end else begin
      for (int a = 0; a < 6; a++)
        for (int b = a + 1; b < 7; b++)
          for (int c = b + 1; c < 8; c++) begin
            if (n == p) r = (8'd1 << a) | (8'd1 << b) | (8'd1 << c);
            n++;
          end
    end
    return r;
  endfunction

  logic [7:0] col [NW];
  for (genvar g = 0; g < NW; g++) begin : g_col
    assign col[g] = hcol(g);
  end

  logic [7:0]  syn;
  logic [7:0]  enc;
  logic [DW-1:0] flip;
  logic        hit;
  logic [6:0]  pos;
  logic [1:0]  status;

  always_comb begin
    syn = '0;
    for (int p = 0; p < DW; p++) if (in_data[p]) syn ^= col[p];
    for (int k = 0; k < CW; k++) if (in_check[k]) syn ^= col[DW + k];
  end

  always_comb begin
    enc = '0;
    for (int p = 0; p < DW; p++) if (enc_data[p]) enc ^= col[p];
  end
  assign enc_check = enc;

  always_comb begin
    hit = 1'b0;
    pos = '0;
    for (int p = 0; p < NW; p++)
      if (syn == col[p]) begin
        hit = 1'b1;
        pos = 7'(p);
      end
  end

  for (genvar g = 0; g < DW; g++) begin : g_flip
    assign flip[g] = (syn == col[g]);
  end

  assign status = (syn == '0) ? ST_CLEAN : (hit ? ST_CORR : ST_UNC);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid    <= 1'b0;
      out_data     <= '0;
      out_status   <= ST_CLEAN;
      out_pos      <= '0;
      out_syndrome <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_data     <= in_data ^ flip;
        out_status   <= status;
        out_pos      <= pos;
        out_syndrome <= syn;
      end
    end
  end

  AST_VALID_RISE: assert property (@(posedge clk) disable iff (rst) in_valid |=> out_valid); // R3
  AST_VALID_IDLE: assert property (@(posedge clk) disable iff (rst) !in_valid |=> !out_valid); // R3
  AST_STATUS_LEGAL: assert property (@(posedge clk) disable iff (rst) out_valid |-> out_status != 2'd3); // R6
  AST_CLEAN_PASS: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_status == ST_CLEAN) |-> (out_data == $past(in_data) && out_syndrome == 8'd0)); // R2
  AST_CORR_ONE_FLIP: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_status == ST_CORR && out_pos < 7'd64) |-> $countones(out_data ^ $past(in_data)) == 1); // R4
  AST_CHECK_ERR_PASS: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_status == ST_CORR && out_pos >= 7'd64) |-> out_data == $past(in_data)); // R5
  AST_UNC_PASS: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_status == ST_UNC) |-> (out_data == $past(in_data) && out_pos == 7'd0)); // R6
  AST_CLEAN_POS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_status == ST_CLEAN) |-> out_pos == 7'd0); // R7
  AST_HOLD: assert property (@(posedge clk) disable iff (rst)
    !$past(in_valid) |-> $stable(out_data) && $stable(out_status)); // R3
endmodule

// File: tb/sim_secded72_decoder.sv
`timescale 1ns/1ps
module sim_secded72_decoder;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst, in_valid;
  logic [63:0] in_data, enc_data, out_data;
  logic [7:0]  in_check, enc_check, out_syndrome;
  logic        out_valid;
  logic [1:0]  out_status;
  logic [6:0]  out_pos;

  secded72_decoder u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data), .in_check(in_check),
    .enc_data(enc_data), .enc_check(enc_check), .out_valid(out_valid), .out_data(out_data),
    .out_status(out_status), .out_pos(out_pos), .out_syndrome(out_syndrome));

  int checks = 0;
  int errors = 0;
  logic [7:0] tcol [72];

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] syn_of(input logic [63:0] d, input logic [7:0] c);
    logic [7:0] s = '0;
    for (int i = 0; i < 64; i++) if (d[i]) s ^= tcol[i];
    for (int k = 0; k < 8; k++) if (c[k]) s ^= tcol[64 + k];
    return s;
  endfunction

  function automatic logic [63:0] rnd64();
    return {$urandom(), $urandom()};
  endfunction

  task automatic decode(input logic [63:0] d, input logic [7:0] c);
    @(negedge clk);
    in_valid = 1'b1; in_data = d; in_check = c;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic expect_out(input string req, input logic [1:0] st, input logic [6:0] p,
                            input logic [63:0] d, input logic [7:0] s);
    check(out_valid == 1'b1, "R3 valid", 64'(out_valid), 64'd1);
    check(out_status == st, {req, " status"}, 64'(out_status), 64'(st));
    check(out_pos == p, {req, " pos"}, 64'(out_pos), 64'(p));
    check(out_data == d, {req, " data"}, out_data, d);
    check(out_syndrome == s, "R8 syndrome", 64'(out_syndrome), 64'(s));
  endtask

  initial begin
    int n;
    logic [7:0] w5 [8];
    w5 = '{8'h1F, 8'h2F, 8'h4F, 8'h8F, 8'h37, 8'h57, 8'h97, 8'h67};
    n = 0;
    for (int a = 0; a < 8; a++)
      for (int b = a + 1; b < 8; b++)
        for (int c = b + 1; c < 8; c++) begin
          tcol[n] = (8'd1 << a) | (8'd1 << b) | (8'd1 << c);
          n++;
        end
    for (int k = 0; k < 8; k++) begin
      tcol[56 + k] = w5[k];
      tcol[64 + k] = 8'd1 << k;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [63:0] d, d2;
    logic [7:0]  c, c2;
    int seed;
    seed = $urandom(32'h5EC0_DED7);
    rst = 1'b1; in_valid = 1'b0; in_data = '0; in_check = '0; enc_data = '0;
    repeat (3) @(negedge clk);
    check(out_valid == 0 && out_status == 0 && out_pos == 0 && out_data == 0 && out_syndrome == 0,
          "R9 reset", {out_data[31:0], 8'(out_valid), 8'(out_status), 8'(out_pos), out_syndrome}, 64'd0);
    rst = 1'b0;

    // R2: encoder and clean words
    for (int t = 0; t < 24; t++) begin
      d = (t == 0) ? 64'd0 : (t == 1) ? '1 : rnd64();
      enc_data = d;
      #1;
      check(enc_check == syn_of(d, 8'd0), "R2 encoder", 64'(enc_check), 64'(syn_of(d, 8'd0)));
      decode(d, enc_check);
      expect_out("R2 clean", 2'd0, 7'd0, d, 8'd0);
    end

    // R3: no strobe, no valid, outputs held
    d2 = out_data;
    @(negedge clk);
    check(out_valid == 1'b0, "R3 idle", 64'(out_valid), 64'd0);
    check(out_data == d2, "R3 hold", out_data, d2);

    // R1 R4 R5: every single-bit position
    for (int p = 0; p < 72; p++) begin
      d = rnd64();
      enc_data = d;
      #1;
      c = enc_check;
      d2 = d; c2 = c;
      if (p < 64) d2[p] = ~d2[p]; else c2[p - 64] = ~c2[p - 64];
      decode(d2, c2);
      if (p < 64) expect_out("R4 R1 data bit", 2'd1, 7'(p), d, tcol[p]);
      else        expect_out("R5 R1 check bit", 2'd1, 7'(p), d2, tcol[p]);
    end

    // R6: double errors
    for (int t = 0; t < 40; t++) begin
      int p1, p2;
      d = rnd64();
      enc_data = d;
      #1;
      c = enc_check;
      p1 = $urandom_range(71, 0);
      p2 = (p1 + $urandom_range(71, 1)) % 72;
      d2 = d; c2 = c;
      if (p1 < 64) d2[p1] = ~d2[p1]; else c2[p1 - 64] = ~c2[p1 - 64];
      if (p2 < 64) d2[p2] = ~d2[p2]; else c2[p2 - 64] = ~c2[p2 - 64];
      decode(d2, c2);
      expect_out("R6 double", 2'd2, 7'd0, d2, syn_of(d2, c2));
    end

    // R7: odd-weight syndromes outside the column set (0x3B weight 5, 0x7F weight 7)
    for (int t = 0; t < 2; t++) begin
      d = rnd64();
      enc_data = d;
      #1;
      c2 = enc_check ^ ((t == 0) ? 8'h3B : 8'h7F);
      decode(d, c2);
      expect_out("R7 odd unmatched", 2'd2, 7'd0, d, (t == 0) ? 8'h3B : 8'h7F);
    end

    // R9: reset after activity
    rst = 1'b1;
    @(negedge clk);
    check(out_valid == 0 && out_status == 0 && out_pos == 0 && out_data == 0 && out_syndrome == 0,
          "R9 reset again", out_data, 64'd0);
    rst = 1'b0;

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule